// File: doc/BRIEF.md
# Split-Capable Auto-Reload Interval Timer

This block is an interval timer that counts a 16-bit value upward and, when the value rolls over from all-ones, starts again from a programmable reload value. It does not restart from zero. Each rollover sets a sticky flag and can raise an interrupt request, so software gets a periodic event whose period is set by the reload value. A split setting turns the counter into two separate 8-bit auto-reload timers. Each of the two has its own reload byte and its own flag.

The count advances on a count-enable pulse taken from one of three sources: every system clock cycle, one pulse in every twelve system clock cycles, or one pulse for every eight pulses of an external oscillator tick. The external tick is already synchronised to the system clock. A fourth select code stops the count. Software loads the count and reload bytes through a byte-wide write port. It clears the flags through a separate clear input.

Each rollover that is allowed to interrupt also produces a one-cycle wake request. The wake request lets a sleeping system resume on a timer event.

Top module: `split_reload_timer`

## Requirements
- R1: With `splitMode`=0, `runEn`=1 and a count-enable pulse, `count` increments by one. When `count` is 16'hFFFF, the next value is the 16-bit reload value `{reload high byte, reload low byte}` and `ovfHigh` becomes 1.
- R2: With `splitMode`=1, the low byte `count[7:0]` advances on every count-enable pulse, whatever `runEn` is. From 8'hFF it loads the low reload byte and sets `ovfLow`.
- R3: With `splitMode`=1, the high byte `count[15:8]` advances on a count-enable pulse only while `runEn`=1. From 8'hFF it loads the high reload byte and sets `ovfHigh`. The low byte never carries into it.
- R4: `clkSel` selects the count-enable source. Code 0 gives every cycle. Code 1 gives one pulse per 12 cycles, from a free-running divider that is cleared by reset and pulses in the 12th, 24th, ... cycle after reset is released. Code 3 gives no pulses, so the count holds.
- R5: `clkSel`=2 gives one count-enable pulse on every 8th `extTick` pulse after reset, counted by a free-running divider that advances on each `extTick`.
- R6: When `wrEn`=1, `wrSel` picks the target: 0 is the count low byte, 1 is the count high byte, 2 is the reload low byte, 3 is the reload high byte. A count write appears on `count` after the next clock edge and replaces any step or reload that the written timer would make in that cycle. In 16-bit mode, a write to either count byte freezes the other byte for that cycle, and no flag is set. A reload written in the same cycle as a rollover takes effect only at the next rollover.
- R7: `ovfLow` and `ovfHigh` stay set until cleared by `flagClr[0]` (low) or `flagClr[1]` (high). If a set and a clear happen in the same cycle, the set wins. `ovfLow` is never set in 16-bit mode.
- R8: `irq` is `ovfHigh` in 16-bit mode. In split mode it is `ovfHigh` OR (`ovfLow` AND `lowIrqEn`).
- R9: `wakeReq` is 1 for exactly the one cycle in which a flag becomes set by an interrupt-eligible rollover. That means any high-byte rollover, or a low-byte rollover in split mode while `lowIrqEn`=1.
- R10: While `rstN`=0, `count`, both reload bytes, both flags, `irq`, `wakeReq` and both dividers are zero.
- R11: With `splitMode`=0 and `runEn`=0, `count` holds its value unless a count byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extTick | input | 1 | Synchronised one-cycle pulse from the external oscillator |
| clkSel | input | 2 | Count-enable source: 0 every cycle, 1 divide-by-12, 2 external divide-by-8, 3 stopped |
| splitMode | input | 1 | 1 selects two 8-bit timers, 0 selects one 16-bit timer |
| runEn | input | 1 | Run control for the 16-bit timer, or for the high byte in split mode |
| lowIrqEn | input | 1 | Lets the low flag raise `irq` and `wakeReq` in split mode |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 count low, 1 count high, 2 reload low, 3 reload high |
| wrData | input | 8 | Write data byte |
| flagClr | input | 2 | Flag clear: bit 0 low flag, bit 1 high flag |
| count | output | 16 | Current count value |
| ovfLow | output | 1 | Sticky low-byte rollover flag |
| ovfHigh | output | 1 | Sticky high-byte or 16-bit rollover flag |
| irq | output | 1 | Interrupt request |
| wakeReq | output | 1 | One-cycle wake pulse on an interrupt-eligible rollover |

## Verification
Some properties are checked by assertions on every cycle. These are:
- flags stay set until cleared;
- a count byte write lands;
- the count holds when stopped or not running;
- a 16-bit rollover from all-ones raises the high flag and the wake pulse;
- `irq` and `wakeReq` never appear without a flag.

Other behaviour needs whole scenarios, so the bench checks it against a reference model on every cycle. This covers the exact reload values after a rollover, the phase of the divide-by-12 and divide-by-8 pulses since reset, the separation of the two split timers, same-cycle write and rollover collisions, and interrupt gating by `lowIrqEn`.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic [1:0] {
    SRC_SYS     = 2'd0,
    SRC_SYS_DIV = 2'd1,
    SRC_EXT_DIV = 2'd2,
    SRC_OFF     = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    WR_CNT_LO = 2'd0,
    WR_CNT_HI = 2'd1,
    WR_REL_LO = 2'd2,
    WR_REL_HI = 2'd3
  } wrSel_e;

  // Per-lane strobes from control to datapath; index 0 is the low lane.
  typedef struct packed {
    logic [1:0] wrCnt;
    logic [1:0] wrRel;
    logic [1:0] load;
    logic [1:0] step;
    logic [1:0] setFlag;
    logic       wake;
  } laneStrobe_t;

endpackage

// File: rtl/srt_prescale.sv
module srt_prescale #(
  parameter int SYS_DIV = 12,
  parameter int EXT_DIV = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extTick,
  input  logic [1:0] clkSel,
  output logic       tick
);
  import srt_pkg::*;

  localparam int SYS_W = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int EXT_W = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;

  logic [SYS_W-1:0] sysCnt;
  logic [EXT_W-1:0] extCnt;
  logic sysLast, extLast;

  assign sysLast = (sysCnt == SYS_W'(SYS_DIV - 1));
  assign extLast = (extCnt == EXT_W'(EXT_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysCnt <= '0;
    end else begin
      sysCnt <= sysLast ? '0 : sysCnt + SYS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extCnt <= '0;
    end else if (extTick) begin
      extCnt <= extLast ? '0 : extCnt + EXT_W'(1);
    end
  end

  always_comb begin
    unique case (srcSel_e'(clkSel))
      SRC_SYS:     tick = 1'b1;
      SRC_SYS_DIV: tick = sysLast;
      SRC_EXT_DIV: tick = extTick && extLast;
      default:     tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl #(
  parameter int HALF_W = 8
) (
  input  logic                  tick,
  input  logic                  splitMode,
  input  logic                  runEn,
  input  logic                  lowIrqEn,
  input  logic                  wrEn,
  input  logic [1:0]            wrSel,
  input  logic [2*HALF_W-1:0]   count,
  input  logic [1:0]            flags,
  output srt_pkg::laneStrobe_t  strobe,
  output logic                  irq
);
  import srt_pkg::*;

  logic [1:0] full;
  logic [1:0] adv;
  logic       adv16, wrap16;

  assign full[0] = &count[HALF_W-1:0];
  assign full[1] = &count[2*HALF_W-1:HALF_W];

  always_comb begin
    strobe = '0;
    adv    = '0;
    adv16  = 1'b0;
    wrap16 = 1'b0;

    if (wrEn) begin
      unique case (wrSel_e'(wrSel))
        WR_CNT_LO: strobe.wrCnt[0] = 1'b1;
        WR_CNT_HI: strobe.wrCnt[1] = 1'b1;
        WR_REL_LO: strobe.wrRel[0] = 1'b1;
        default:   strobe.wrRel[1] = 1'b1;
      endcase
    end

    if (splitMode) begin
      adv[0] = tick && !strobe.wrCnt[0];
      adv[1] = tick && runEn && !strobe.wrCnt[1];
      for (int i = 0; i < 2; i++) begin
        strobe.step[i]    = adv[i] && !full[i];
        strobe.load[i]    = adv[i] && full[i];
        strobe.setFlag[i] = adv[i] && full[i];
      end
      strobe.wake = strobe.setFlag[1] | (strobe.setFlag[0] & lowIrqEn);
    end else begin
      adv16 = tick && runEn && !(|strobe.wrCnt);
      wrap16 = adv16 && full[0] && full[1];
      strobe.step[0]    = adv16 && !wrap16;
      strobe.step[1]    = adv16 && full[0] && !full[1];
      strobe.load       = {wrap16, wrap16};
      strobe.setFlag[1] = wrap16;
      strobe.wake       = wrap16;
    end
  end

  assign irq = flags[1] | (splitMode & lowIrqEn & flags[0]);

endmodule

// File: rtl/srt_datapath.sv
module srt_datapath #(
  parameter int HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  srt_pkg::laneStrobe_t  strobe,
  input  logic [HALF_W-1:0]     wrData,
  input  logic [1:0]            flagClr,
  output logic [2*HALF_W-1:0]   count,
  output logic [1:0]            flags,
  output logic                  wakeReq
);
  import srt_pkg::*;

  localparam int LANES = 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HALF_W-1:0] cntR;
    logic [HALF_W-1:0] relR;
    logic              flagR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntR <= '0;
      end else if (strobe.wrCnt[g]) begin
        cntR <= wrData;
      end else if (strobe.load[g]) begin
        cntR <= relR;
      end else if (strobe.step[g]) begin
        cntR <= cntR + HALF_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        relR <= '0;
      end else if (strobe.wrRel[g]) begin
        relR <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagR <= 1'b0;
      end else begin
        flagR <= strobe.setFlag[g] | (flagR & ~flagClr[g]);
      end
    end

    assign count[g*HALF_W +: HALF_W] = cntR;
    assign flags[g] = flagR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeReq <= 1'b0;
    end else begin
      wakeReq <= strobe.wake;
    end
  end

endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer #(
  parameter int HALF_W  = 8,
  parameter int SYS_DIV = 12,
  parameter int EXT_DIV = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extTick,
  input  logic [1:0]          clkSel,
  input  logic                splitMode,
  input  logic                runEn,
  input  logic                lowIrqEn,
  input  logic                wrEn,
  input  logic [1:0]          wrSel,
  input  logic [HALF_W-1:0]   wrData,
  input  logic [1:0]          flagClr,
  output logic [2*HALF_W-1:0] count,
  output logic                ovfLow,
  output logic                ovfHigh,
  output logic                irq,
  output logic                wakeReq
);
  import srt_pkg::*;

  logic        tick;
  logic [1:0]  flags;
  laneStrobe_t strobe;

  srt_prescale #(.SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV)) u_prescale (
    .clk     (clk),
    .rstN    (rstN),
    .extTick (extTick),
    .clkSel  (clkSel),
    .tick    (tick)
  );

  srt_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .tick      (tick),
    .splitMode (splitMode),
    .runEn     (runEn),
    .lowIrqEn  (lowIrqEn),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .count     (count),
    .flags     (flags),
    .strobe    (strobe),
    .irq       (irq)
  );

  srt_datapath #(.HALF_W(HALF_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .flagClr (flagClr),
    .count   (count),
    .flags   (flags),
    .wakeReq (wakeReq)
  );

  assign ovfLow  = flags[0];
  assign ovfHigh = flags[1];

endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
  parameter int HALF_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          clkSel,
  input logic                splitMode,
  input logic                runEn,
  input logic                wrEn,
  input logic [1:0]          wrSel,
  input logic [HALF_W-1:0]   wrData,
  input logic [1:0]          flagClr,
  input logic [2*HALF_W-1:0] count,
  input logic                ovfLow,
  input logic                ovfHigh,
  input logic                irq,
  input logic                wakeReq
);

  logic cntWrite;
  assign cntWrite = wrEn && !wrSel[1];

  a_r7_high_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfHigh && !flagClr[1] |=> ovfHigh);

  a_r7_low_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfLow && !flagClr[0] |=> ovfLow);

  a_r6_low_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrSel == 2'd0 |=> count[HALF_W-1:0] == $past(wrData));

  a_r4_stopped: assert property (@(posedge clk) disable iff (!rstN)
    clkSel == 2'd3 && !cntWrite |=> count == $past(count));

  a_r11_run_hold: assert property (@(posedge clk) disable iff (!rstN)
    !splitMode && !runEn && !cntWrite |=> count == $past(count));

  a_r1_wrap_flag: assert property (@(posedge clk) disable iff (!rstN)
    !splitMode && runEn && clkSel == 2'd0 && !wrEn && (&count) |=> ovfHigh && wakeReq);

  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ovfHigh || ovfLow));

  a_r9_wake_flag: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (ovfHigh || ovfLow));

endmodule

bind split_reload_timer srt_checker #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clkSel    (clkSel),
  .splitMode (splitMode),
  .runEn     (runEn),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .wrData    (wrData),
  .flagClr   (flagClr),
  .count     (count),
  .ovfLow    (ovfLow),
  .ovfHigh   (ovfHigh),
  .irq       (irq),
  .wakeReq   (wakeReq)
);

// File: tb/split_reload_timer_bench.sv
module split_reload_timer_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, extTick, splitMode, runEn, lowIrqEn, wrEn;
  logic [1:0]  clkSel, wrSel, flagClr;
  logic [7:0]  wrData;
  logic [15:0] count;
  logic        ovfLow, ovfHigh, irq, wakeReq;

  int checks = 0;
  int failures = 0;

  split_reload_timer u_split_reload_timer (
    .clk(clk), .rstN(rstN), .extTick(extTick), .clkSel(clkSel),
    .splitMode(splitMode), .runEn(runEn), .lowIrqEn(lowIrqEn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .flagClr(flagClr),
    .count(count), .ovfLow(ovfLow), .ovfHigh(ovfHigh), .irq(irq),
    .wakeReq(wakeReq)
  );

  // Reference model built from the requirements
  logic [7:0] mLo, mHi, mRelLo, mRelHi;
  logic       mFl, mFh, mWake;
  int         m12, m8;
  logic       tk, setL, setH;
  logic [7:0] nLo, nHi;

  function automatic logic srcTick(input logic [1:0] sel, input int c12, input int c8,
                                   input logic ext);
    case (sel)
      2'd0:    return 1'b1;
      2'd1:    return c12 == 11;
      2'd2:    return ext && (c8 == 7);
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLo <= 0; mHi <= 0; mRelLo <= 0; mRelHi <= 0;
      mFl <= 0; mFh <= 0; mWake <= 0; m12 <= 0; m8 <= 0;
    end else begin
      tk = srcTick(clkSel, m12, m8, extTick);
      setL = 0; setH = 0; nLo = mLo; nHi = mHi;
      if (splitMode) begin
        if (wrEn && wrSel == 2'd0) nLo = wrData;
        else if (tk) begin
          if (mLo == 8'hFF) begin nLo = mRelLo; setL = 1; end
          else nLo = mLo + 8'd1;
        end
        if (wrEn && wrSel == 2'd1) nHi = wrData;
        else if (tk && runEn) begin
          if (mHi == 8'hFF) begin nHi = mRelHi; setH = 1; end
          else nHi = mHi + 8'd1;
        end
      end else begin
        if (wrEn && wrSel == 2'd0) nLo = wrData;
        else if (wrEn && wrSel == 2'd1) nHi = wrData;
        else if (tk && runEn) begin
          if ({mHi, mLo} == 16'hFFFF) begin nLo = mRelLo; nHi = mRelHi; setH = 1; end
          else {nHi, nLo} = {mHi, mLo} + 16'd1;
        end
      end
      mLo <= nLo;
      mHi <= nHi;
      if (wrEn && wrSel == 2'd2) mRelLo <= wrData;
      if (wrEn && wrSel == 2'd3) mRelHi <= wrData;
      mFl <= setL | (mFl & ~flagClr[0]);
      mFh <= setH | (mFh & ~flagClr[1]);
      mWake <= setH | (splitMode & setL & lowIrqEn);
      m12 <= (m12 == 11) ? 0 : m12 + 1;
      if (extTick) m8 <= (m8 == 7) ? 0 : m8 + 1;
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, "count", {16'd0, count}, {16'd0, mHi, mLo});
    check("R7", "ovfLow", {31'd0, ovfLow}, {31'd0, mFl});
    check("R7", "ovfHigh", {31'd0, ovfHigh}, {31'd0, mFh});
    check("R8", "irq", {31'd0, irq}, {31'd0, mFh | (splitMode & lowIrqEn & mFl)});
    check("R9", "wakeReq", {31'd0, wakeReq}, {31'd0, mWake});
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] data, input string tag);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    step(tag);
    wrEn = 1'b0;
  endtask

  task automatic randomPhase(input int n, input logic split, input logic [1:0] sel,
                             input int runOdds, input string tag);
    splitMode = split; clkSel = sel;
    for (int i = 0; i < n; i++) begin
      extTick  = 1'($urandom % 2);
      runEn    = ($urandom % runOdds) != 0;
      wrEn     = ($urandom % 24) == 0;
      wrSel    = 2'($urandom % 4);
      wrData   = ($urandom % 2 == 1) ? (8'hF0 | 8'($urandom % 16)) : 8'($urandom);
      flagClr  = ($urandom % 16 == 0) ? 2'($urandom % 4) : 2'b00;
      if ($urandom % 64 == 0) lowIrqEn = ~lowIrqEn;
      step(tag);
    end
    wrEn = 1'b0; flagClr = 2'b00;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; extTick = 0; clkSel = 0; splitMode = 0; runEn = 0; lowIrqEn = 0;
    wrEn = 0; wrSel = 0; wrData = 0; flagClr = 0;
    repeat (3) @(negedge clk);
    check("R10", "count", {16'd0, count}, 32'd0);
    check("R10", "flags", {30'd0, ovfHigh, ovfLow}, 32'd0);
    check("R10", "irq/wake", {30'd0, irq, wakeReq}, 32'd0);
    rstN = 1;

    // R6: load reload 1234 and count FFFE with the timer stopped
    regWrite(2'd2, 8'h34, "R6");
    regWrite(2'd3, 8'h12, "R6");
    regWrite(2'd0, 8'hFE, "R6");
    regWrite(2'd1, 8'hFF, "R6");
    check("R6", "count after writes", {16'd0, count}, 32'h0000FFFE);

    // R1: roll over from FFFF to the reload value
    runEn = 1;
    step("R1");
    check("R1", "count before wrap", {16'd0, count}, 32'h0000FFFF);
    step("R1");
    check("R1", "count after wrap", {16'd0, count}, 32'h00001234);
    check("R1", "ovfHigh after wrap", {31'd0, ovfHigh}, 32'd1);
    check("R9", "wake on wrap", {31'd0, wakeReq}, 32'd1);
    check("R7", "no low flag in 16-bit", {31'd0, ovfLow}, 32'd0);
    step("R1");
    check("R9", "wake one cycle", {31'd0, wakeReq}, 32'd0);
    flagClr = 2'b10;
    step("R7");
    flagClr = 2'b00;
    check("R7", "high flag cleared", {31'd0, ovfHigh}, 32'd0);

    // R2/R3/R8: split mode, low lane rolls over while high lane is stopped
    splitMode = 1; runEn = 0; lowIrqEn = 0;
    regWrite(2'd0, 8'hFF, "R2");
    step("R2");
    check("R2", "low reload", {24'd0, count[7:0]}, 32'h34);
    check("R3", "high held", {24'd0, count[15:8]}, 32'h12);
    check("R2", "low flag", {31'd0, ovfLow}, 32'd1);
    check("R8", "irq gated", {31'd0, irq}, 32'd0);
    lowIrqEn = 1;
    step("R8");
    check("R8", "irq enabled", {31'd0, irq}, 32'd1);
    flagClr = 2'b01;
    step("R7");
    flagClr = 2'b00;

    randomPhase(1500, 1'b0, 2'd0, 8, "R1");
    randomPhase(1500, 1'b0, 2'd0, 2, "R11");
    randomPhase(1500, 1'b1, 2'd0, 8, "R2");
    randomPhase(1500, 1'b1, 2'd0, 2, "R3");
    randomPhase(2000, 1'b0, 2'd1, 8, "R4");
    randomPhase(2000, 1'b1, 2'd2, 8, "R5");
    randomPhase(500, 1'b0, 2'd3, 8, "R4");
    randomPhase(1000, 1'b1, 2'd0, 4, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule